// File: doc/BRIEF.md
# SD/MMC Command Path Engine

This block is the host side of the command line of an SD/MMC bus. Software loads a 32-bit argument, then writes a command word holding the 6-bit index, a two-bit response kind and a start bit. The engine builds a 48-bit frame with a CRC7 and shifts it out most significant bit first. It then releases the line and, if a response is expected, hunts for a start bit. It collects a 48-bit or 136-bit response, stores it in four response words and ends the command by raising one sticky status flag.

All bus-bit activity advances on a one-cycle bit strobe `bus_tick`, produced by a clock divider outside the block. Software observes completion by polling the status word and acknowledges flags by writing ones to the clear word. The response kind decides which flag ends the command: "sent" for no response, "response end" for a good response, "CRC fail" for a short response whose CRC does not match, and "timeout" when no start bit arrives in time.

Top module: `sdcmd_engine`

## Requirements
- R1: A started command drives 48 bits on `cmd_out`, one per `bus_tick`, most significant first: a 0, a 1, the 6-bit index (command word bits 5:0), the 32-bit argument, the CRC7 of those first 40 bits (polynomial x^7+x^3+1, register starting at zero), and a final 1. Index 0 with argument 0 gives the final byte 0x95.
- R2: After reset every word reads zero and `cmd_oe` is low. The word offsets are: argument 0x08, command 0x0C, response words one to four 0x14/0x18/0x1C/0x20, status 0x34, clear 0x38. The command word holds the index in bits 5:0, a data-follows mark in bit 6, a stop mark in bit 7, the response kind in bits 9:8 and start/enable in bit 12. Every other bit reads zero.
- R3: With response kind 0, the end of the frame sets status bit 7 and ends the command without sampling `cmd_in`.
- R4: With kind 1 and a matching CRC, status bit 6 is set. Response bits 39:8 (the 32 bits after the start bit, the transmitter bit and the 6-bit index) land in response word one. Words two to four keep their values.
- R5: With kind 1 and a CRC mismatch, status bit 0 is set instead of bit 6. The payload is still stored in response word one.
- R6: With kind 2 the response CRC is not checked, and a bad CRC still ends the command on status bit 6.
- R7: With kind 3 a 136-bit response is taken. The 128 bits that follow the start bit, the transmitter bit and the 6 reserved bits fill response words one to four, most significant word in word one. No CRC is checked, and status bit 6 is set.
- R8: After the frame, if `cmd_in` is sampled high on 64 consecutive bit strobes, status bit 2 is set. A start bit seen on the 64th strobe is still accepted as a response.
- R9: Status flags stay set until cleared by writing 1 to the same bit of the clear word. When a clear and a new flag fall on the same clock edge, the new flag survives and the other cleared bits drop.
- R10: A write to the command word while a command is in progress is ignored entirely. The enable bit clears by itself when the command ends.
- R11: `cmd_oe` is high only while the 48 frame bits are presented. It is low while the engine waits for and samples a response.
- R12: Between bit strobes the line output and the frame and response shift state do not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_tick | input | 1 | One-cycle strobe marking each bus bit time |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| cmd_out | output | 1 | Command line value to drive |
| cmd_oe | output | 1 | Command line drive enable; low means released |
| cmd_in | input | 1 | Sampled command line |

## Verification
The clear write and the end of a command can land on the same clock edge. In that case one flag is being raised while software wipes the status word. The bench provokes this by leaving a "sent" flag from an earlier command. On the strobe that carries the last response bit, it issues a clear of all bits timed to the edge where the "response end" flag is registered. The status read afterwards must show the new flag alone: the old flag is gone and the new one is not lost.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int FRAME_W     = 48;
  localparam int LONG_W      = 136;
  localparam int LONG_DATA_W = 128;
  localparam int CRC_W       = 7;
  localparam int CRC_MSG_W   = FRAME_W - CRC_W - 1;

  localparam logic [7:0] OFF_ARG  = 8'h08;
  localparam logic [7:0] OFF_CMD  = 8'h0C;
  localparam logic [7:0] OFF_RSP0 = 8'h14;
  localparam logic [7:0] OFF_RSP1 = 8'h18;
  localparam logic [7:0] OFF_RSP2 = 8'h1C;
  localparam logic [7:0] OFF_RSP3 = 8'h20;
  localparam logic [7:0] OFF_STAT = 8'h34;
  localparam logic [7:0] OFF_CLR  = 8'h38;

  localparam int CB_EN   = 12;
  localparam int FB_CRC  = 0;
  localparam int FB_TO   = 2;
  localparam int FB_REND = 6;
  localparam int FB_SENT = 7;

  localparam logic [31:0] CMD_KEEP  = 32'h0000_13FF;
  localparam logic [31:0] FLAG_KEEP = 32'h0000_00C5;

  typedef enum logic [1:0] {
    RSP_NONE        = 2'd0,
    RSP_SHORT       = 2'd1,
    RSP_SHORT_NOCRC = 2'd2,
    RSP_LONG        = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'd0,
    CTL_SEND = 2'd1,
    CTL_WAIT = 2'd2
  } ctl_state_e;

  typedef enum logic [1:0] {
    RX_OK      = 2'd0,
    RX_CRCERR  = 2'd1,
    RX_TIMEOUT = 2'd2
  } rx_res_e;

  // Serial CRC7, x^7 + x^3 + 1, MSB of the message first, zero seed.
  function automatic logic [CRC_W-1:0] crc7_calc(input logic [CRC_MSG_W-1:0] msg);
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = '0;
    for (int i = CRC_MSG_W - 1; i >= 0; i--) begin
      fb  = msg[i] ^ acc[CRC_W-1];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ 7'h09;
    end
    return acc;
  endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
  import sdcmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               line_out,
  output logic               line_oe,
  output logic               done
);

  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               busy_q, busy_d;
  logic               done_q, done_d;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (load) begin
      sr_d   = frame;
      cnt_d  = CNT_W'(FRAME_W);
      busy_d = 1'b1;
    end else if (busy_q && bus_tick) begin
      sr_d  = {sr_q[FRAME_W-2:0], 1'b1};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign line_out = busy_q ? sr_q[FRAME_W-1] : 1'b1;
  assign line_oe  = busy_q;
  assign done     = done_q;

  // R1
  tx_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((cnt_q != '0) && (cnt_q <= CNT_W'(FRAME_W))));

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bus_tick && !load) |=> ($stable(sr_q) && $stable(line_out)));

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
  import sdcmd_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_tick,
  input  logic                   arm,
  input  logic                   long_mode,
  input  logic                   chk_crc,
  input  logic                   line_in,
  output logic                   done,
  output rx_res_e                result,
  output logic [LONG_DATA_W-1:0] data_o
);

  localparam int CNT_W = $clog2(LONG_W + 1);
  localparam int TO_W  = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {RXS_IDLE, RXS_HUNT, RXS_TAKE} rx_state_e;

  rx_state_e              st_q, st_d;
  logic [LONG_DATA_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [TO_W-1:0]        wcnt_q, wcnt_d;
  logic                   done_q, done_d;
  logic                   to_q, to_d;
  logic                   long_q, long_d;
  logic                   chk_q, chk_d;
  logic                   crc_bad;

  always_comb begin
    st_d   = st_q;
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    wcnt_d = wcnt_q;
    done_d = 1'b0;
    to_d   = to_q;
    long_d = long_q;
    chk_d  = chk_q;
    case (st_q)
      RXS_IDLE: begin
        if (arm) begin
          st_d   = RXS_HUNT;
          wcnt_d = '0;
          to_d   = 1'b0;
          long_d = long_mode;
          chk_d  = chk_crc;
        end
      end
      RXS_HUNT: begin
        if (bus_tick) begin
          if (!line_in) begin
            st_d  = RXS_TAKE;
            cnt_d = long_q ? CNT_W'(LONG_W - 1) : CNT_W'(FRAME_W - 1);
          end else if (wcnt_q == TO_W'(TIMEOUT - 1)) begin
            st_d   = RXS_IDLE;
            done_d = 1'b1;
            to_d   = 1'b1;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      end
      RXS_TAKE: begin
        if (bus_tick) begin
          sr_d  = {sr_q[LONG_DATA_W-2:0], line_in};
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            st_d   = RXS_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: st_d = RXS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RXS_IDLE;
      sr_q   <= '0;
      cnt_q  <= '0;
      wcnt_q <= '0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
      long_q <= 1'b0;
      chk_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      wcnt_q <= wcnt_d;
      done_q <= done_d;
      to_q   <= to_d;
      long_q <= long_d;
      chk_q  <= chk_d;
    end
  end

  // Short frame after the start bit sits in sr_q[46:0]: the CRC covers
  // the start bit (0) plus bits 46:8, and is carried in bits 7:1.
  assign crc_bad = chk_q && !long_q &&
                   (crc7_calc({1'b0, sr_q[FRAME_W-2:CRC_W+1]}) != sr_q[CRC_W:1]);

  assign done   = done_q;
  assign result = to_q ? RX_TIMEOUT : (crc_bad ? RX_CRCERR : RX_OK);
  assign data_o = sr_q;

  // R8
  rx_wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RXS_HUNT) |-> (wcnt_q < TO_W'(TIMEOUT)));

  // R12
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_tick && !arm) |=> $stable(sr_q));

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int RSP_TIMEOUT = 64,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in
);

  localparam int RSP_WORDS = LONG_DATA_W / 32;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ctl_state_e             state_q, state_d;
  logic [31:0]            arg_q, cmd_q, cmd_d, flags_q, flags_d;
  logic [31:0]            resp_q [RSP_WORDS];
  logic [31:0]            resp_d [RSP_WORDS];
  logic                   arg_wr, cmd_wr, clr_wr, accept, start;
  logic [31:0]            set_vec, clr_mask;
  logic                   complete;
  rsp_kind_e              kind_q;
  logic [CRC_MSG_W-1:0]   crc_msg;
  logic [FRAME_W-1:0]     frame;
  logic                   tx_done, rx_arm, rx_done;
  rx_res_e                rx_result;
  logic [LONG_DATA_W-1:0] rx_data;

  assign arg_wr = reg_we && (reg_addr == ADDR_W'(OFF_ARG));
  assign cmd_wr = reg_we && (reg_addr == ADDR_W'(OFF_CMD));
  assign clr_wr = reg_we && (reg_addr == ADDR_W'(OFF_CLR));
  assign accept = cmd_wr && (state_q == CTL_IDLE) && !cmd_q[CB_EN];
  assign start  = accept && reg_wdata[CB_EN];
  assign kind_q = rsp_kind_e'(cmd_q[9:8]);

  assign crc_msg = {2'b01, reg_wdata[5:0], arg_q};
  assign frame   = {crc_msg, crc7_calc(crc_msg), 1'b1};

  sdcmd_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .bus_tick (bus_tick),
    .load     (start),
    .frame    (frame),
    .line_out (cmd_out),
    .line_oe  (cmd_oe),
    .done     (tx_done)
  );

  sdcmd_rx #(.TIMEOUT(RSP_TIMEOUT)) u_rx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_tick  (bus_tick),
    .arm       (rx_arm),
    .long_mode (kind_q == RSP_LONG),
    .chk_crc   (kind_q == RSP_SHORT),
    .line_in   (cmd_in),
    .done      (rx_done),
    .result    (rx_result),
    .data_o    (rx_data)
  );

  // Control sequence and completion events
  always_comb begin
    state_d = state_q;
    rx_arm  = 1'b0;
    set_vec = '0;
    case (state_q)
      CTL_IDLE: if (start) state_d = CTL_SEND;
      CTL_SEND: begin
        if (tx_done) begin
          if (kind_q == RSP_NONE) begin
            state_d          = CTL_IDLE;
            set_vec[FB_SENT] = 1'b1;
          end else begin
            state_d = CTL_WAIT;
            rx_arm  = 1'b1;
          end
        end
      end
      CTL_WAIT: begin
        if (rx_done) begin
          state_d = CTL_IDLE;
          case (rx_result)
            RX_OK:     set_vec[FB_REND] = 1'b1;
            RX_CRCERR: set_vec[FB_CRC]  = 1'b1;
            default:   set_vec[FB_TO]   = 1'b1;
          endcase
        end
      end
      default: state_d = CTL_IDLE;
    endcase
  end

  assign complete = (set_vec != '0);
  assign clr_mask = clr_wr ? reg_wdata : '0;
  assign flags_d  = ((flags_q & ~clr_mask) | set_vec) & FLAG_KEEP;

  always_comb begin
    cmd_d = cmd_q;
    if (accept)        cmd_d = reg_wdata & CMD_KEEP;
    else if (complete) cmd_d = cmd_q & ~(32'd1 << CB_EN);
  end

  // Response capture: long fills all words, short only the first
  always_comb begin
    for (int w = 0; w < RSP_WORDS; w++) resp_d[w] = resp_q[w];
    if ((state_q == CTL_WAIT) && rx_done && (rx_result != RX_TIMEOUT)) begin
      if (kind_q == RSP_LONG) begin
        for (int w = 0; w < RSP_WORDS; w++)
          resp_d[w] = rx_data[LONG_DATA_W-1-32*w -: 32];
      end else begin
        resp_d[0] = rx_data[CRC_MSG_W-1:CRC_W+1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= CTL_IDLE;
      arg_q   <= '0;
      cmd_q   <= '0;
      flags_q <= '0;
      for (int w = 0; w < RSP_WORDS; w++) resp_q[w] <= '0;
    end else begin
      state_q <= state_d;
      if (arg_wr) arg_q <= reg_wdata;
      cmd_q   <= cmd_d;
      flags_q <= flags_d;
      for (int w = 0; w < RSP_WORDS; w++) resp_q[w] <= resp_d[w];
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_W'(OFF_ARG):  reg_rdata = arg_q;
      ADDR_W'(OFF_CMD):  reg_rdata = cmd_q;
      ADDR_W'(OFF_RSP0): reg_rdata = resp_q[0];
      ADDR_W'(OFF_RSP1): reg_rdata = resp_q[1];
      ADDR_W'(OFF_RSP2): reg_rdata = resp_q[2];
      ADDR_W'(OFF_RSP3): reg_rdata = resp_q[3];
      ADDR_W'(OFF_STAT): reg_rdata = flags_q;
      default:           reg_rdata = '0;
    endcase
  end

  // R11
  line_released_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == CTL_WAIT) |-> !cmd_oe);

  // R10
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cmd_wr && (state_q != CTL_IDLE)) |=> $stable(cmd_q[9:0]));

  // R9
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !clr_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R3
  sent_kind_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(flags_q[FB_SENT]) |-> (cmd_q[9:8] == 2'b00));

endmodule

// File: tb/tb_sdcmd_engine.sv
`timescale 1ns/1ps
module tb_sdcmd_engine;

  localparam logic [7:0] A_ARG = 8'h08, A_CMD = 8'h0C, A_R0 = 8'h14, A_R1 = 8'h18,
                         A_R2 = 8'h1C, A_R3 = 8'h20, A_ST = 8'h34, A_CL = 8'h38;
  localparam logic [31:0] S_CRC = 32'h01, S_TO = 32'h04, S_REND = 32'h40, S_SENT = 32'h80;

  // {kind[80:79], idx[78:73], arg[72:41], badcrc[40], payload[39:8], delay[7:0]}
  localparam logic [80:0] VECS [6] = '{
    {2'd0, 6'd0,  32'h0000_0000, 1'b0, 32'h0000_0000, 8'd0},
    {2'd1, 6'd17, 32'h0000_1234, 1'b0, 32'h0000_0900, 8'd2},
    {2'd1, 6'd13, 32'hA5A5_0000, 1'b1, 32'hDEAD_BEEF, 8'd5},
    {2'd2, 6'd41, 32'h40FF_8000, 1'b1, 32'h80FF_8000, 8'd1},
    {2'd0, 6'd12, 32'hFFFF_FFFF, 1'b0, 32'h0000_0000, 8'd0},
    {2'd1, 6'd8,  32'h0000_01AA, 1'b0, 32'h0000_01AA, 8'd0}
  };

  logic        clk, rst_n, bus_tick, reg_we, cmd_in;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cmd_out, cmd_oe;

  int          n_chk, n_fail;
  logic        smp_out, smp_oe, oe_ok, rel_ok;
  logic [47:0] cap_frame;
  logic [31:0] rdv;

  sdcmd_engine dut (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [6:0] bcrc(input logic [39:0] m);
    logic [6:0] r = 7'd0;
    for (int i = 39; i >= 0; i--)
      r = {r[5:0], 1'b0} ^ (((m[i] ^ r[6]) != 1'b0) ? 7'h09 : 7'h00);
    return r;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  // One bus bit: sample the line, present din, pulse the strobe for one clock.
  task automatic step(input logic din, input logic clr_here);
    @(negedge clk); smp_out = cmd_out; smp_oe = cmd_oe; cmd_in = din; bus_tick = 1'b1;
    @(negedge clk); bus_tick = 1'b0;
    if (clr_here) begin reg_we = 1'b1; reg_addr = A_CL; reg_wdata = 32'hFFFF_FFFF; end
    @(negedge clk); reg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic cap_steps(input int n);
    for (int k = 0; k < n; k++) begin
      step(1'b1, 1'b0);
      cap_frame = {cap_frame[46:0], smp_out};
      if (!smp_oe) oe_ok = 1'b0;
    end
  endtask

  task automatic start_cmd(input logic [1:0] kind, input logic [5:0] idx, input logic [31:0] arg);
    wr(A_ARG, arg);
    wr(A_CMD, 32'h1000 | (32'(kind) << 8) | 32'(idx));
    oe_ok = 1'b1;
  endtask

  function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, bcrc({2'b01, idx, arg}), 1'b1};
  endfunction

  task automatic respond_short(input logic [5:0] idx, input logic [31:0] pay, input logic bad,
                               input int delay, input logic clr_last);
    logic [47:0] f;
    f = {2'b00, idx, pay, bcrc({2'b00, idx, pay}) ^ (bad ? 7'h01 : 7'h00), 1'b1};
    rel_ok = 1'b1;
    for (int k = 0; k < delay; k++) begin step(1'b1, 1'b0); if (smp_oe) rel_ok = 1'b0; end
    for (int k = 47; k >= 0; k--) begin
      step(f[k], clr_last && (k == 0));
      if (smp_oe) rel_ok = 1'b0;
    end
    step(1'b1, 1'b0);
  endtask

  task automatic run_vec(input logic [80:0] v);
    logic [1:0]  kind;
    logic [5:0]  idx;
    logic [31:0] arg, pay, exp_st;
    logic        bad;
    kind = v[80:79]; idx = v[78:73]; arg = v[72:41]; bad = v[40]; pay = v[39:8];
    wr(A_CL, 32'hFFFF_FFFF);
    start_cmd(kind, idx, arg);
    cap_steps(48);
    chk("R1 frame", 64'(cap_frame), 64'(exp_frame(idx, arg)));
    chk("R11 drive during frame", 64'(oe_ok), 64'd1);
    if (kind == 2'd0) begin
      exp_st = S_SENT;
      step(1'b1, 1'b0);
    end else begin
      respond_short(idx, pay, bad, int'(v[7:0]), 1'b0);
      chk("R11 released during response", 64'(rel_ok), 64'd1);
      exp_st = (kind == 2'd1 && bad) ? S_CRC : S_REND;
      rd(A_R0, rdv);
      chk("R4 R5 short payload in word one", 64'(rdv), 64'(pay));
    end
    rd(A_ST, rdv);
    if (kind == 2'd0)                chk("R3 sent flag", 64'(rdv), 64'(exp_st));
    else if (kind == 2'd2)           chk("R6 no CRC check", 64'(rdv), 64'(exp_st));
    else if (bad)                    chk("R5 CRC fail flag", 64'(rdv), 64'(exp_st));
    else                             chk("R4 response end flag", 64'(rdv), 64'(exp_st));
    rd(A_CMD, rdv);
    chk("R10 enable self-clears", 64'(rdv), 64'((32'(kind) << 8) | 32'(idx)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [127:0] ld;
    logic [135:0] lf;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_tick = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; cmd_in = 1'b1;
    smp_out = 1'b1; smp_oe = 1'b0; oe_ok = 1'b1; rel_ok = 1'b1; cap_frame = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state
    chk("R2 reset oe", 64'(cmd_oe), 64'd0);
    foreach (VECS[i]) begin end
    rd(A_ARG, rdv); chk("R2 reset arg", 64'(rdv), 64'd0);
    rd(A_CMD, rdv); chk("R2 reset cmd", 64'(rdv), 64'd0);
    rd(A_ST,  rdv); chk("R2 reset status", 64'(rdv), 64'd0);
    rd(A_R3,  rdv); chk("R2 reset resp4", 64'(rdv), 64'd0);
    wr(A_CMD, 32'hFFFF_EFFF);
    rd(A_CMD, rdv); chk("R2 command field mask", 64'(rdv), 64'h03FF);
    wr(A_CMD, 32'h0);

    // Table walk
    for (int i = 0; i < 6; i++) begin
      run_vec(VECS[i]);
      if (i == 0) chk("R1 known CRC byte", 64'(cap_frame[7:0]), 64'h95);
    end

    // R7: long response, garbage internal CRC ignored
    ld = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211;
    lf = {2'b00, 6'h3F, ld};
    wr(A_CL, 32'hFFFF_FFFF);
    start_cmd(2'd3, 6'd2, 32'h0);
    cap_steps(48);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0);
    for (int k = 135; k >= 0; k--) step(lf[k], 1'b0);
    step(1'b1, 1'b0);
    rd(A_ST, rdv); chk("R7 long end flag", 64'(rdv), 64'(S_REND));
    rd(A_R0, rdv); chk("R7 word one", 64'(rdv), 64'h0123_4567);
    rd(A_R1, rdv); chk("R7 word two", 64'(rdv), 64'h89AB_CDEF);
    rd(A_R2, rdv); chk("R7 word three", 64'(rdv), 64'hFEDC_BA98);
    rd(A_R3, rdv); chk("R7 word four", 64'(rdv), 64'h7654_3211);

    // R4: short response leaves words two to four alone
    wr(A_CL, 32'hFFFF_FFFF);
    start_cmd(2'd1, 6'd7, 32'h0);
    cap_steps(48);
    respond_short(6'd7, 32'hCAFE_F00D, 1'b0, 1, 1'b0);
    rd(A_R0, rdv); chk("R4 word one", 64'(rdv), 64'hCAFE_F00D);
    rd(A_R3, rdv); chk("R4 word four kept", 64'(rdv), 64'h7654_3211);

    // R8: timeout after 64 idle strobes, not before
    wr(A_CL, 32'hFFFF_FFFF);
    start_cmd(2'd1, 6'd5, 32'h0);
    cap_steps(48);
    for (int k = 0; k < 63; k++) step(1'b1, 1'b0);
    rd(A_ST, rdv); chk("R8 no timeout at 63", 64'(rdv), 64'd0);
    chk("R11 released while hunting", 64'(cmd_oe), 64'd0);
    step(1'b1, 1'b0);
    rd(A_ST, rdv); chk("R8 timeout at 64", 64'(rdv), 64'(S_TO));
    rd(A_CMD, rdv); chk("R10 enable cleared on timeout", 64'(rdv), 64'h0105);

    // R8: start bit on the 64th strobe is accepted
    wr(A_CL, 32'hFFFF_FFFF);
    start_cmd(2'd1, 6'd9, 32'h0);
    cap_steps(48);
    respond_short(6'd9, 32'h1357_9BDF, 1'b0, 63, 1'b0);
    rd(A_ST, rdv); chk("R8 late start accepted", 64'(rdv), 64'(S_REND));

    // R12: no strobe, no movement
    wr(A_CL, 32'hFFFF_FFFF);
    start_cmd(2'd2, 6'd3, 32'h0F0F_0F0F);
    begin
      logic held = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (cmd_out !== 1'b0 || cmd_oe !== 1'b1) held = 1'b0;
      end
      chk("R12 line holds without strobe", 64'(held), 64'd1);
    end
    // R10: write during a command is ignored
    cap_steps(10);
    wr(A_CMD, 32'h133F);
    rd(A_CMD, rdv); chk("R10 busy write ignored", 64'(rdv), 64'h1203);
    cap_steps(38);
    chk("R10 frame unaffected", 64'(cap_frame), 64'(exp_frame(6'd3, 32'h0F0F_0F0F)));
    respond_short(6'd3, 32'h2468_ACE0, 1'b1, 2, 1'b0);
    rd(A_ST, rdv); chk("R6 bad CRC tolerated", 64'(rdv), 64'(S_REND));

    // R9: clear and new flag on the same edge
    wr(A_CL, 32'hFFFF_FFFF);
    start_cmd(2'd0, 6'd0, 32'h0);
    cap_steps(48);
    step(1'b1, 1'b0);
    rd(A_ST, rdv); chk("R9 sticky before clear", 64'(rdv), 64'(S_SENT));
    start_cmd(2'd1, 6'd11, 32'h0);
    cap_steps(48);
    respond_short(6'd11, 32'h0, 1'b0, 1, 1'b1);
    rd(A_ST, rdv); chk("R9 set wins over clear", 64'(rdv), 64'(S_REND));
    wr(A_CL, S_REND);
    rd(A_ST, rdv); chk("R9 write-one clear", 64'(rdv), 64'd0);

    report();
  end

endmodule